// File: doc/BRIEF.md
# Open-Drain Two-Wire Pin-Pair Control Register

This block is a single 32-bit memory-mapped control word that lets software operate one clock pin and one data pin of a two-wire serial bus by hand. Each pin owns a direction bit, an output value bit, a pull-up disable bit and a read-only sampled level. A pin is never driven high. Software releases it by making it an input, so the external pull-up lifts the line, and pulls it low by making it an output whose value is 0.

Direction and value fields are protected by write-enable mask bits carried in the same write word. A field changes only when its mask is set, so one pin can be reconfigured without a read-modify-write of the other pin's direction or value. The pull-up disable bits are plain stored bits: every write loads them, and software keeps them by writing back what it read. The pad inputs pass through a two-flop synchroniser before they can be read.

Field layout within the word is the same for both pins. The clock pin uses base bit 0 and the data pin uses base bit 8. Offsets from the base are: +0 direction mask (write only), +1 direction (1 = output), +2 value mask (write only), +3 output value, +4 sampled pad level (read only), +5 pull-up disable. All other bits read 0.

Top module: `gpio_pair_reg`

## Requirements
- R1: While reset is asserted and before the first write, the read word is 0, both pad enables are low and both pull-up disable outputs are low.
- R2: A write with a pin's direction mask (base+0) set and direction bit (base+1) clear makes that pin an input: its pad enable is low after the write edge and base+1 reads 0.
- R3: A write with base+0 and base+2 set, base+1 set and base+3 clear makes that pin an output driving 0: its pad enable is high after the write edge.
- R4: A direction or value field whose mask bit is clear in a write keeps its previous content. With no write, all stored fields hold.
- R5: A pin's pad enable is high exactly when that pin's stored direction is output and its stored value is 0. An output holding value 1 does not drive the pad.
- R6: A write that touches one pin's fields, with the other pin's mask bits clear, leaves the other pin's direction, value and pad enable unchanged.
- R7: Each write loads both pull-up disable bits (bits 5 and 13) directly from the write word, with no mask. The stored bits appear on the pull-up disable outputs and in the read word.
- R8: A pad input level appears in its sampled bit (bits 4 and 12) on the second rising clock edge after it changes, and not on the first. Writes to the sampled bits have no effect.
- R9: Mask bits (base+0, base+2) and all bits outside the two 6-bit fields read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe, one word per cycle |
| wr_data | input | 32 | Write word with mask bits and fields |
| rd_data | output | 32 | Current register contents |
| scl_pad_in | input | 1 | Clock pad level, asynchronous |
| sda_pad_in | input | 1 | Data pad level, asynchronous |
| scl_pad_oe | output | 1 | Clock pad pull-low enable (pad data tied 0) |
| sda_pad_oe | output | 1 | Data pad pull-low enable (pad data tied 0) |
| scl_pu_dis | output | 1 | Clock pad pull-up disable |
| sda_pu_dis | output | 1 | Data pad pull-up disable |

## Verification
The masked-hold behaviour matters only when the field was already in a state that differs from the one the write carries. The bench therefore first forces each pin into each of its four direction and value combinations with a fully masked write. From each of those states it applies all sixteen mask and value patterns for that pin, with the other pin's masks clear and its pull-up bit toggled. The synchroniser delay is visible only at the ports when the pad level changes between edges. The bench flips a pad at a falling edge and reads the word after one and after two rising edges.

// File: rtl/gpio_pair_reg.sv
module gpio_pair_reg #(
  parameter int DW     = 32,
  parameter int STRIDE = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  output logic [DW-1:0] rd_data,
  input  logic          scl_pad_in,
  input  logic          sda_pad_in,
  output logic          scl_pad_oe,
  output logic          sda_pad_oe,
  output logic          scl_pu_dis,
  output logic          sda_pu_dis
);
  localparam int NPIN    = 2;
  localparam int O_DMSK  = 0;
  localparam int O_DIR   = 1;
  localparam int O_VMSK  = 2;
  localparam int O_VAL   = 3;
  localparam int O_IN    = 4;
  localparam int O_PU    = 5;

  logic [NPIN-1:0] dir_q, val_q, pu_q, s1_q, s2_q, pad_in, oe;
  logic [1:0]      arm_q;

  assign pad_in = {sda_pad_in, scl_pad_in};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q <= '0;
      val_q <= '0;
      pu_q  <= '0;
      s1_q  <= '0;
      s2_q  <= '0;
      arm_q <= '0;
    end else begin
      s1_q <= pad_in;
      s2_q <= s1_q;
      if (arm_q != 2'd3) arm_q <= arm_q + 2'd1;
      if (wr_en) begin
        for (int p = 0; p < NPIN; p++) begin
          if (wr_data[p*STRIDE+O_DMSK]) dir_q[p] <= wr_data[p*STRIDE+O_DIR];
          if (wr_data[p*STRIDE+O_VMSK]) val_q[p] <= wr_data[p*STRIDE+O_VAL];
          pu_q[p] <= wr_data[p*STRIDE+O_PU];
        end
      end
    end
  end

  assign oe = dir_q & ~val_q;

  always_comb begin
    rd_data = '0;
    for (int p = 0; p < NPIN; p++) begin
      rd_data[p*STRIDE+O_DIR] = dir_q[p];
      rd_data[p*STRIDE+O_VAL] = val_q[p];
      rd_data[p*STRIDE+O_IN]  = s2_q[p];
      rd_data[p*STRIDE+O_PU]  = pu_q[p];
    end
  end

  assign scl_pad_oe = oe[0];
  assign sda_pad_oe = oe[1];
  assign scl_pu_dis = pu_q[0];
  assign sda_pu_dis = pu_q[1];

  for (genvar g = 0; g < NPIN; g++) begin : g_chk
    localparam int B = g*STRIDE;

    a_r2_release: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_data[B+O_DMSK] && !wr_data[B+O_DIR])
        |=> (!oe[g] && !rd_data[B+O_DIR]));

    a_r3_pull_low: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_data[B+O_DMSK] && wr_data[B+O_DIR] &&
       wr_data[B+O_VMSK] && !wr_data[B+O_VAL]) |=> oe[g]);

    a_r4_dir_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!wr_en || !wr_data[B+O_DMSK]) |=> $stable(rd_data[B+O_DIR]));

    a_r4_val_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!wr_en || !wr_data[B+O_VMSK]) |=> $stable(rd_data[B+O_VAL]));

    a_r7_pu_load: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> (rd_data[B+O_PU] == $past(wr_data[B+O_PU])));

    a_r8_sync_delay: assert property (@(posedge clk) disable iff (!rst_n)
      arm_q[1] |-> (rd_data[B+O_IN] == $past(pad_in[g], 2)));
  end

  a_r5_oe_vs_read: assert property (@(posedge clk) disable iff (!rst_n)
    scl_pad_oe |-> (rd_data[O_DIR] && !rd_data[O_VAL]));

endmodule

// File: tb/sim_gpio_pair_reg.sv
module sim_gpio_pair_reg;
  localparam int CLK_PERIOD = 10;

  logic        clk = 0;
  logic        rst_n = 0;
  logic        wr_en = 0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic        scl_in = 1, sda_in = 1;
  logic        scl_oe, sda_oe, scl_pu, sda_pu;

  int total = 0, bad = 0;
  bit done = 0;

  logic [1:0] m_dir = '0, m_val = '0, m_pu = '0, m_in = 2'b11;

  always #(CLK_PERIOD/2) clk = ~clk;

  gpio_pair_reg u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .rd_data(rd_data), .scl_pad_in(scl_in), .sda_pad_in(sda_in),
    .scl_pad_oe(scl_oe), .sda_pad_oe(sda_oe),
    .scl_pu_dis(scl_pu), .sda_pu_dis(sda_pu)
  );

  function automatic logic [31:0] exp_word();
    logic [31:0] w = '0;
    for (int p = 0; p < 2; p++) begin
      w[p*8+1] = m_dir[p];
      w[p*8+3] = m_val[p];
      w[p*8+4] = m_in[p];
      w[p*8+5] = m_pu[p];
    end
    return w;
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic write(input logic [31:0] d);
    @(negedge clk);
    wr_en = 1; wr_data = d;
    for (int p = 0; p < 2; p++) begin
      if (d[p*8+0]) m_dir[p] = d[p*8+1];
      if (d[p*8+2]) m_val[p] = d[p*8+3];
      m_pu[p] = d[p*8+5];
    end
    @(negedge clk);
    wr_en = 0; wr_data = '0;
  endtask

  task automatic check_all(input string tag);
    check({tag, " R4 R6 R9 word"}, rd_data, exp_word());
    check({tag, " R2 R3 R5 oe"}, {30'd0, sda_oe, scl_oe}, {30'd0, m_dir & ~m_val});
    check({tag, " R7 pu"}, {30'd0, sda_pu, scl_pu}, {30'd0, m_pu});
  endtask

  initial begin
    #(CLK_PERIOD*100000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 word in reset", rd_data, 32'h0);
    check("R1 oe in reset", {30'd0, sda_oe, scl_oe}, 32'h0);
    check("R1 pu in reset", {30'd0, sda_pu, scl_pu}, 32'h0);
    rst_n = 1;
    @(negedge clk);
    check("R1 after release", rd_data & ~32'h0000_1010, 32'h0);
    repeat (3) @(negedge clk);

    // R2 R3 R4 R5 R6 R7 R9 sweep
    for (int p = 0; p < 2; p++)
      for (int s = 0; s < 4; s++)
        for (int c = 0; c < 16; c++)
          for (int u = 0; u < 2; u++) begin
            logic [31:0] d;
            d = '0;
            d[p*8 +: 4] = {s[0], 1'b1, s[1], 1'b1};
            d[p*8+5] = u[0];
            d[(1-p)*8+5] = m_pu[1-p];
            write(d);
            check_all("setup");
            d = '0;
            d[p*8 +: 4] = c[3:0];
            d[p*8+5] = u[0];
            d[(1-p)*8+5] = ~m_pu[1-p];
            write(d);
            check_all("sweep");
          end

    // R9 all ones
    write(32'hFFFF_FFFF);
    check_all("R9 all ones");
    check("R9 literal", rd_data, 32'h0000_3A3A);

    // R8 synchroniser delay and read-only sampled bits
    @(negedge clk);
    scl_in = 0;
    @(negedge clk);
    check("R8 one edge", rd_data[4], 1'b1);
    @(negedge clk);
    m_in[0] = 0;
    check("R8 two edges", rd_data[4], 1'b0);
    sda_in = 0;
    @(negedge clk);
    check("R8 data one edge", rd_data[12], 1'b1);
    @(negedge clk);
    m_in[1] = 0;
    check("R8 data two edges", rd_data[12], 1'b0);
    write(32'h0000_1010);
    check("R8 write ignored", rd_data & 32'h0000_1010, 32'h0);
    check_all("R8 after write");
    scl_in = 1; sda_in = 1;
    repeat (2) @(negedge clk);
    m_in = 2'b11;
    check_all("R8 back high");

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule